// File: doc/BRIEF.md
# Video Memory Block-Copy Engine

This block copies bytes from the 16-bit system address space into an 8 KB video memory window. Software loads a source pointer, a destination pointer and an 8-bit control word. The low seven bits of the control word give the length in 16-byte blocks, minus one. Bit 7 of the written word picks the mode. With bit 7 clear, the whole length moves in one burst that starts at once. With bit 7 set, the engine is armed and moves one 16-byte block for each rising edge of the blanking request.

The source and destination pointers advance by one per byte and keep their values between blocks. Each byte lands at the window base with the low 13 destination bits. Certain source regions are never read; those bytes are filled with 0xFF. A transfer that would run the destination past 0xFFFF is cut short and flagged. When a burst ends, the remaining block count is written back into the control word, and software can read it there. While a burst runs the block holds `busy_o` high, and the requesting processor is stalled for that time.

Top module: `vram_dma`

## Requirements
- R1: A write to the control word with bit 7 = 0, made while not busy, starts a burst of (bits[6:0] + 1) × 16 bytes, each written once to video memory in address order.
- R2: A write with bit 7 = 1 arms blanking mode (`blank_mode_o` = 1) and moves nothing. Each rising edge of `blank_req_i` while armed and not busy moves exactly 16 bytes. A rising edge while not armed starts nothing.
- R3: If the destination plus the burst length reaches or passes 0x10000, the burst is clipped to 0x10000 minus the destination, and control read-back bit 7 is set.
- R4: A source byte whose address has bits [15:13] = 3'b100, or is above 0xFDFF, is written as 0xFF and raises no `mem_req_o`. Any other source byte is read and written as `mem_rdata_i`.
- R5: Each byte is written to address 0x8000 | (destination & 0x1FFF). Source and destination each advance by 1 per byte, and the source wraps from 0xFFFF to 0x0000.
- R6: `busy_o` is high for 1 + N × C + 4 cycles, where N is the number of bytes in the burst and C is 2, or 4 when `dbl_speed_i` = 1 at the start, plus any grant-stall cycles. `done_o` pulses in the last busy cycle.
- R7: After a burst, the control read-back is ((remaining bytes / 16) − 1) & 0xFF, with bit 7 forced high if the burst was clipped. It reads 0xFF after reset and after a completed transfer.
- R8: If `lcd_en_i` = 0 in the cycle a burst ends, the remaining length is taken as zero, so the control read-back is 0xFF.
- R9: When the control read-back gains bit 7 at the end of a burst, blanking mode is disarmed.
- R10: Source and destination keep their updated values between blanking-mode blocks, so each block continues where the previous one stopped.
- R11: While `busy_o` is high, writes to the control word and to both pointers are ignored.
- R12: A byte from a readable source holds `mem_req_o` and waits while `mem_gnt_i` = 0. Each such cycle lengthens the burst by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control write data: [7] mode, [6:0] block count − 1 |
| ctl_o | output | 8 | Control read-back: [7] clipped or idle, [6:0] remaining code |
| src_we_i | input | 1 | Source pointer write strobe |
| dst_we_i | input | 1 | Destination pointer write strobe |
| addr_wdata_i | input | 16 | Pointer write data |
| blank_req_i | input | 1 | Blanking request; the rising edge moves one block |
| lcd_en_i | input | 1 | Display enabled |
| dbl_speed_i | input | 1 | Double-speed clocking (4 cycles per byte) |
| mem_req_o | output | 1 | System read request |
| mem_addr_o | output | 16 | System read address |
| mem_gnt_i | input | 1 | Read grant; data is valid with the grant |
| mem_rdata_i | input | 8 | System read data |
| vram_we_o | output | 1 | Video memory write strobe |
| vram_addr_o | output | 16 | Video memory write address |
| vram_wdata_o | output | 8 | Video memory write data |
| busy_o | output | 1 | Burst in progress; the processor stalls |
| blank_mode_o | output | 1 | Blanking mode armed |
| done_o | output | 1 | One-cycle pulse in the last busy cycle |

## Verification
The bench aims at the destination clip at 0xFFF0 and checks the read-back 0x82. An engine that did not clip would write 64 bytes and leave bit 7 low. A source that starts at 0xFFF8 tests both the blocked-region fill and the wrap to 0x0000. A wrong region decode would show up as read data where 0xFF belongs, or as a read request into the blocked range. Three blanking blocks in a row must step the read-back through 0x01, 0x00 and 0xFF and then disarm; a design that lost its pointers between blocks would repeat addresses. The bench also drops the grant during a burst, turns the display off at the end of a block, and writes registers while busy. These cases expose wrong cycle counts, a remaining length that is not forced to zero, and a register that a busy write has corrupted.

// File: rtl/vram_dma_pkg.sv
package vram_dma_pkg;
  typedef enum logic [1:0] {X_IDLE, X_BYTE, X_TAIL} xfer_st_e;

  // source regions that are never read: 0x8000-0x9FFF and 0xFE00 upward
  function automatic logic src_open(input logic [15:0] a);
    return !((a[15:13] == 3'b100) || (a > 16'hFDFF));
  endfunction
endpackage

// File: rtl/vram_dma_chunk.sv
module vram_dma_chunk #(
  parameter int AW     = 16,
  parameter int CODE_W = 7,
  parameter int BLK_SH = 4,
  localparam int LEN_W = CODE_W + BLK_SH + 1
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              blank_i,
  input  logic [AW-1:0]     dst_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [LEN_W-1:0]  left_o,
  output logic              clip_o
);
  logic [LEN_W-1:0] total;
  logic [LEN_W-1:0] raw;
  logic [AW:0]      sum;
  logic [AW:0]      room;

  always_comb begin
    total  = (LEN_W'(code_i) + LEN_W'(1)) << BLK_SH;
    raw    = blank_i ? LEN_W'(1 << BLK_SH) : total;
    sum    = {1'b0, dst_i} + (AW+1)'(raw);
    clip_o = sum[AW];
    room   = ((AW+1)'(1) << AW) - {1'b0, dst_i};
    len_o  = clip_o ? LEN_W'(room) : raw;
    left_o = total - len_o;
  end
endmodule

// File: rtl/vram_dma_xfer.sv
module vram_dma_xfer
  import vram_dma_pkg::*;
#(
  parameter int LEN_W    = 12,
  parameter int DATA_W   = 8,
  parameter int TAIL_CYC = 4,
  localparam int TW      = $clog2(TAIL_CYC) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              dbl_i,
  input  logic              src_ok_i,
  input  logic              gnt_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              mem_req_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              busy_o,
  output logic              done_o
);
  xfer_st_e          st_q;
  logic [1:0]        ph_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [TW-1:0]     tail_q;
  logic              dbl_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        last_ph;
  logic              stall;

  always_comb begin
    last_ph   = dbl_q ? 2'd3 : 2'd1;
    mem_req_o = (st_q == X_BYTE) && (ph_q == 2'd0) && src_ok_i;
    stall     = mem_req_o && !gnt_i;
    wr_o      = (st_q == X_BYTE) && (ph_q == last_ph);
    done_o    = (st_q == X_TAIL) && (tail_q == TW'(TAIL_CYC - 1));
    busy_o    = (st_q != X_IDLE);
    wdata_o   = data_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= X_IDLE;
      ph_q   <= '0;
      cnt_q  <= '0;
      tail_q <= '0;
      dbl_q  <= 1'b0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        X_IDLE: if (start_i) begin
          st_q  <= X_BYTE;
          ph_q  <= '0;
          cnt_q <= len_i;
          dbl_q <= dbl_i;
        end
        X_BYTE: begin
          if (ph_q == 2'd0 && !stall) begin
            data_q <= src_ok_i ? rdata_i : '1;
            ph_q   <= ph_q + 2'd1;
          end else if (ph_q == last_ph) begin
            ph_q  <= '0;
            cnt_q <= cnt_q - LEN_W'(1);
            if (cnt_q == LEN_W'(1)) begin
              st_q   <= X_TAIL;
              tail_q <= '0;
            end
          end else if (ph_q != 2'd0) begin
            ph_q <= ph_q + 2'd1;
          end
        end
        X_TAIL: begin
          tail_q <= tail_q + TW'(1);
          if (done_o) st_q <= X_IDLE;
        end
        default: st_q <= X_IDLE;
      endcase
    end
  end

  // back-to-back writes would mean a byte took fewer than 2 cycles
  assert_write_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);

  // a request without grant keeps waiting
  assert_gnt_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !gnt_i) |=> mem_req_o);
endmodule

// File: rtl/vram_dma.sv
module vram_dma
  import vram_dma_pkg::*;
#(
  parameter int AW                 = 16,
  parameter int VW                 = 13,
  parameter int CODE_W             = 7,
  parameter int BLK_SH             = 4,
  parameter int TAIL_CYC           = 4,
  parameter logic [15:0] VRAM_BASE = 16'h8000,
  localparam int CTL_W             = CODE_W + 1,
  localparam int LEN_W             = CODE_W + BLK_SH + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_o,
  input  logic             src_we_i,
  input  logic             dst_we_i,
  input  logic [AW-1:0]    addr_wdata_i,
  input  logic             blank_req_i,
  input  logic             lcd_en_i,
  input  logic             dbl_speed_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_gnt_i,
  input  logic [7:0]       mem_rdata_i,
  output logic             vram_we_o,
  output logic [AW-1:0]    vram_addr_o,
  output logic [7:0]       vram_wdata_o,
  output logic             busy_o,
  output logic             blank_mode_o,
  output logic             done_o
);
  logic [CTL_W-1:0] ctl_q, ctl_nxt, rem_code;
  logic [AW-1:0]    src_q, dst_q;
  logic             arm_q, go_q, term_q, blk_d_q;
  logic [LEN_W-1:0] left_q;
  logic [LEN_W-1:0] c_len, c_left;
  logic             c_clip;
  logic             x_busy, x_wr, x_done, src_ok;
  logic             gp_go, hb_go;

  vram_dma_chunk #(.AW(AW), .CODE_W(CODE_W), .BLK_SH(BLK_SH)) u_chunk (
    .code_i (ctl_q[CODE_W-1:0]),
    .blank_i(arm_q),
    .dst_i  (dst_q),
    .len_o  (c_len),
    .left_o (c_left),
    .clip_o (c_clip)
  );

  vram_dma_xfer #(.LEN_W(LEN_W), .DATA_W(8), .TAIL_CYC(TAIL_CYC)) u_xfer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (go_q),
    .len_i    (c_len),
    .dbl_i    (dbl_speed_i),
    .src_ok_i (src_ok),
    .gnt_i    (mem_gnt_i),
    .rdata_i  (mem_rdata_i),
    .mem_req_o(mem_req_o),
    .wr_o     (x_wr),
    .wdata_o  (vram_wdata_o),
    .busy_o   (x_busy),
    .done_o   (x_done)
  );

  always_comb begin
    src_ok       = src_open(src_q);
    busy_o       = go_q | x_busy;
    gp_go        = ctl_we_i && !busy_o && !ctl_wdata_i[CTL_W-1];
    hb_go        = arm_q && blank_req_i && !blk_d_q && !busy_o;
    rem_code     = CTL_W'(left_q >> BLK_SH) - CTL_W'(1);
    if (!lcd_en_i) rem_code = '1;
    ctl_nxt      = {rem_code[CTL_W-1] | term_q, rem_code[CODE_W-1:0]};
    ctl_o        = ctl_q;
    blank_mode_o = arm_q;
    done_o       = x_done;
    vram_we_o    = x_wr;
    mem_addr_o   = src_q;
    vram_addr_o  = {VRAM_BASE[AW-1:VW], dst_q[VW-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '1;
      src_q   <= '0;
      dst_q   <= '0;
      arm_q   <= 1'b0;
      go_q    <= 1'b0;
      term_q  <= 1'b0;
      blk_d_q <= 1'b0;
      left_q  <= '0;
    end else begin
      go_q    <= gp_go | hb_go;
      blk_d_q <= blank_req_i;
      if (ctl_we_i && !busy_o) begin
        ctl_q <= {1'b0, ctl_wdata_i[CODE_W-1:0]};
        arm_q <= ctl_wdata_i[CTL_W-1];
      end
      if (go_q) begin
        term_q <= c_clip;
        left_q <= c_left;
      end
      if (x_done) begin
        ctl_q <= ctl_nxt;
        if (ctl_nxt[CTL_W-1]) arm_q <= 1'b0;
      end
      if (src_we_i && !busy_o) src_q <= addr_wdata_i;
      else if (x_wr)           src_q <= src_q + AW'(1);
      if (dst_we_i && !busy_o) dst_q <= addr_wdata_i;
      else if (x_wr)           dst_q <= dst_q + AW'(1);
    end
  end

  assert_dst_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vram_we_o |=> (dst_q == $past(dst_q) + AW'(1)));

  assert_ctl_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(ctl_q));

  assert_lcd_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !lcd_en_i) |=> (ctl_q == '1));

  assert_disarm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_q[CTL_W-1]) |-> !arm_q);
endmodule

// File: tb/sim_vram_dma.sv
module sim_vram_dma;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctl_we_i = 1'b0;
  logic [7:0]  ctl_wdata_i = '0;
  logic [7:0]  ctl_o;
  logic        src_we_i = 1'b0, dst_we_i = 1'b0;
  logic [15:0] addr_wdata_i = '0;
  logic        blank_req_i = 1'b0, lcd_en_i = 1'b1, dbl_speed_i = 1'b0;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic        mem_gnt_i = 1'b1;
  logic [7:0]  mem_rdata_i;
  logic        vram_we_o;
  logic [15:0] vram_addr_o;
  logic [7:0]  vram_wdata_o;
  logic        busy_o, blank_mode_o, done_o;

  always #5 clk_i = ~clk_i;

  vram_dma u0 (.*);

  function automatic logic [7:0] fmem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign mem_rdata_i = fmem(mem_addr_o);

  function automatic bit readable(input int a);
    return ((a & 'hE000) != 'h8000) && (a <= 'hFDFF);
  endfunction

  int n_chk = 0, n_fail = 0;
  int m_ctl = 'hFF, m_src = 0, m_dst = 0, exp_cyc = 0;
  bit m_hb = 0;
  logic [23:0] exp_q[$];
  int busy_cnt = 0, stall_cnt = 0, done_cnt = 0;
  bit stall_mode = 0;
  int tick = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (busy_o) busy_cnt++;
    if (done_o) done_cnt++;
    if (mem_req_o && !mem_gnt_i) stall_cnt++;
    if (mem_req_o && !readable(int'(mem_addr_o)))
      chk(0, "R4 read of blocked source", int'(mem_addr_o), 0);
    if (vram_we_o) begin
      if (exp_q.size() == 0) chk(0, "R1 extra byte", int'(vram_addr_o), 0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk(vram_addr_o == e[23:8], "R5 vram address", int'(vram_addr_o), int'(e[23:8]));
        chk(vram_wdata_o == e[7:0], "R4 vram data", int'(vram_wdata_o), int'(e[7:0]));
      end
    end
  end

  always @(posedge clk_i) begin
    #1;
    mem_gnt_i = stall_mode ? (tick % 3 == 0) : 1'b1;
    tick++;
  end

  task automatic model_chunk(input bit hb);
    int rem, len, v;
    bit term;
    rem = ((m_ctl & 127) + 1) * 16;
    len = hb ? 16 : rem;
    term = 0;
    if (m_dst + len >= 65536) begin len = 65536 - m_dst; term = 1; end
    rem -= len;
    for (int i = 0; i < len; i++) begin
      logic [7:0] d;
      d = readable(m_src) ? fmem(16'(m_src)) : 8'hFF;
      exp_q.push_back({16'('h8000 | (m_dst & 'h1FFF)), d});
      m_src = (m_src + 1) & 'hFFFF;
      m_dst = (m_dst + 1) & 'hFFFF;
    end
    if (!lcd_en_i) rem = 0;
    v = ((rem / 16) - 1) & 255;
    m_ctl = v | (term ? 128 : 0);
    if (m_ctl & 128) m_hb = 0;
    exp_cyc = 1 + len * (dbl_speed_i ? 4 : 2) + 4;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_we_i = 1'b1; ctl_wdata_i = v;
    @(posedge clk_i); #1 ctl_we_i = 1'b0;
  endtask

  task automatic wr_ptr(input bit dst, input logic [15:0] v);
    if (dst) dst_we_i = 1'b1; else src_we_i = 1'b1;
    addr_wdata_i = v;
    @(posedge clk_i); #1 src_we_i = 1'b0; dst_we_i = 1'b0;
    if (dst) m_dst = int'(v); else m_src = int'(v);
  endtask

  task automatic pulse_blank();
    blank_req_i = 1'b1;
    @(posedge clk_i); #1 blank_req_i = 1'b0;
  endtask

  task automatic finish_burst(input string req);
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    chk(busy_cnt == exp_cyc + stall_cnt, "R6 busy cycles", busy_cnt, exp_cyc + stall_cnt);
    chk(done_cnt == 1, "R6 done pulse", done_cnt, 1);
    chk(int'(ctl_o) == m_ctl, {req, " control read-back"}, int'(ctl_o), m_ctl);
    chk(exp_q.size() == 0, "R1 bytes missing", exp_q.size(), 0);
    chk(blank_mode_o == m_hb, "R9 blank mode", int'(blank_mode_o), int'(m_hb));
    busy_cnt = 0; stall_cnt = 0; done_cnt = 0;
  endtask

  task automatic gp_burst(input logic [6:0] code, input string req);
    busy_cnt = 0; stall_cnt = 0; done_cnt = 0;
    m_ctl = int'(code); m_hb = 0;
    model_chunk(0);
    wr_ctl({1'b0, code});
    finish_burst(req);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ctl_o == 8'hFF, "R7 reset read-back", int'(ctl_o), 'hFF);
    chk(!busy_o && !blank_mode_o && !vram_we_o, "R11 reset idle", int'(busy_o), 0);
    @(posedge clk_i); #1;

    // R1 R5 R7: plain burst, 48 bytes, normal speed
    wr_ptr(0, 16'h1234); wr_ptr(1, 16'h8010);
    gp_burst(7'd2, "R7");

    // R4 R5 R6: double speed, source in top blocked region wrapping to 0
    dbl_speed_i = 1'b1;
    wr_ptr(0, 16'hFFF8); wr_ptr(1, 16'hA000);
    gp_burst(7'd0, "R4");
    dbl_speed_i = 1'b0;

    // R4: source crossing out of the 0x8000 region
    wr_ptr(0, 16'h9FF8); wr_ptr(1, 16'h8100);
    gp_burst(7'd1, "R4");

    // R3: destination clip at 0x10000, read-back 0x82
    wr_ptr(0, 16'h0400); wr_ptr(1, 16'hFFF0);
    gp_burst(7'd3, "R3");

    // R2: blanking edge with nothing armed starts nothing
    pulse_blank();
    repeat (3) @(negedge clk_i);
    chk(!busy_o, "R2 unarmed edge", int'(busy_o), 0);
    chk(int'(ctl_o) == m_ctl, "R2 unarmed read-back", int'(ctl_o), m_ctl);
    @(posedge clk_i); #1;

    // R2 R9 R10: three blanking blocks, pointers continue
    wr_ptr(0, 16'h4000); wr_ptr(1, 16'h9000);
    wr_ctl(8'h82);
    m_ctl = 'h02; m_hb = 1;
    @(negedge clk_i);
    chk(blank_mode_o && !busy_o, "R2 armed without moving", int'(busy_o), 0);
    chk(ctl_o == 8'h02, "R2 armed read-back", int'(ctl_o), 2);
    @(posedge clk_i); #1;
    for (int k = 0; k < 3; k++) begin
      busy_cnt = 0; stall_cnt = 0; done_cnt = 0;
      model_chunk(1);
      pulse_blank();
      finish_burst("R10");
      @(posedge clk_i); #1;
    end

    // R8: display off at end of a block
    wr_ptr(0, 16'h2000); wr_ptr(1, 16'h8800);
    wr_ctl(8'h83);
    m_ctl = 'h03; m_hb = 1;
    lcd_en_i = 1'b0;
    busy_cnt = 0; stall_cnt = 0; done_cnt = 0;
    model_chunk(1);
    pulse_blank();
    finish_burst("R8");
    lcd_en_i = 1'b1;
    @(posedge clk_i); #1;

    // R12: grant withheld on some cycles
    wr_ptr(0, 16'h3000); wr_ptr(1, 16'h8200);
    stall_mode = 1;
    gp_burst(7'd0, "R12");
    stall_mode = 0;
    @(posedge clk_i); #1;

    // R11: writes during a burst are ignored
    wr_ptr(0, 16'h5000); wr_ptr(1, 16'h8300);
    busy_cnt = 0; stall_cnt = 0; done_cnt = 0;
    m_ctl = 1; m_hb = 0;
    model_chunk(0);
    wr_ctl(8'h01);
    ctl_we_i = 1'b1; ctl_wdata_i = 8'h85;
    src_we_i = 1'b1; dst_we_i = 1'b1; addr_wdata_i = 16'h0000;
    @(posedge clk_i); #1;
    ctl_we_i = 1'b0; src_we_i = 1'b0; dst_we_i = 1'b0;
    finish_burst("R11");
    // following burst must continue from the unmodified pointers
    gp_burst(7'd0, "R11");

    summary();
    $finish;
  end
endmodule